// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits between two independent access ports and a shared word-addressed memory. Each clock cycle it compares the two ports' enables and addresses. When both ports select the same word it grants the word to one port and pulls the other port's active-low busy flag low. It also suppresses that port's write strobe, so a colliding write never reaches the array. Reads and writes are treated alike: only the enable and address take part in the decision.

A mode input selects master or slave operation. In master mode the block arbitrates and drives both busy flags. In slave mode it does no arbitration and holds both busy outputs high. A separate active-low inhibit input per port then gates that port's writes, so several devices can follow one master's decision. The winner is kept in a register for as long as the collision lasts. A write suppressed during a collision is discarded and is never replayed.

Top module: `dp_busy_arb`

## Requirements
- R1: In master mode a collision exists only when both enables are high and the two AW-bit addresses are equal; with no collision both busy outputs read 1.
- R2: A port whose enable and address are unchanged from the previous cycle wins against a port whose enable or address changed into the match; the changed port's busy reads 0 in that same cycle.
- R3: The two busy outputs are never 0 in the same cycle.
- R4: The write inputs have no effect on either busy output.
- R5: A port's write output is its write input ANDed with its enable, and is 0 in every cycle in which that port's busy reads 0.
- R6: In slave mode (mode input 0) both busy outputs read 1. A port's inhibit input at 0 forces that port's write output to 0, and an inhibit input at 1 lets the write pass.
- R7: A busy output returns to 1 in the same cycle in which the addresses differ or either enable is 0.
- R8: When both ports change into a matching access in the same cycle, or neither changed, the left port wins and the right busy reads 0.
- R9: While the collision persists, the winner is held, even if both ports move together to a new matching address.
- R10: A suppressed write is dropped. After busy returns to 1, the write output follows only the current write input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = arbitrate and drive busy, 0 = follow the inhibit inputs |
| l_en_i | input | 1 | Left port enable |
| l_addr_i | input | AW | Left port word address |
| l_we_i | input | 1 | Left port write request |
| l_inh_ni | input | 1 | Left write inhibit, active low, used in slave mode |
| r_en_i | input | 1 | Right port enable |
| r_addr_i | input | AW | Right port word address |
| r_we_i | input | 1 | Right port write request |
| r_inh_ni | input | 1 | Right write inhibit, active low, used in slave mode |
| l_busy_o | output | 1 | Left busy, active low |
| r_busy_o | output | 1 | Right busy, active low |
| l_we_o | output | 1 | Gated left write strobe to the array |
| r_we_o | output | 1 | Gated right write strobe to the array |

## Verification
The ownership decision and the write gating can land in the same cycle: a port can start a colliding access and raise its write request in the very cycle it loses. The bench provokes this with simultaneous matching starts and with late arrivals that carry a write. It judges the result by checking that the losing port's write output stays 0 in that first cycle, not one cycle later. A second overlap is a ring of release and re-entry: a collision ends while the blocked port still holds its write request. The bench then checks that no delayed write appears and that the next collision is decided afresh.

// File: rtl/dp_arb_pkg.sv
package dp_arb_pkg;
  typedef enum logic {
    OWN_LEFT  = 1'b0,
    OWN_RIGHT = 1'b1
  } owner_e;

  localparam int unsigned NPORT = 2;
  localparam int unsigned PL    = 0;
  localparam int unsigned PR    = 1;
endpackage

// File: rtl/dp_addr_match.sv
module dp_addr_match #(
  parameter int unsigned AW = 16
) (
  input  logic          a_en_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic          b_en_i,
  input  logic [AW-1:0] b_addr_i,
  output logic          match_o
);
  assign match_o = a_en_i & b_en_i & (a_addr_i == b_addr_i);
endmodule

// File: rtl/dp_port_track.sv
module dp_port_track #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic          chg_o
);
  logic          en_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en_i;
      addr_q <= addr_i;
    end
  end

  // access differs from last cycle: counts as a late arrival
  assign chg_o = (en_i != en_q) | (addr_i != addr_q);
endmodule

// File: rtl/dp_owner_ctl.sv
module dp_owner_ctl
  import dp_arb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   master_i,
  input  logic   match_i,
  input  logic   l_chg_i,
  input  logic   r_chg_i,
  output owner_e owner_o
);
  logic   coll_q;
  owner_e owner_q;
  owner_e fresh;

  // right wins only if it was settled and left moved; ties go left
  assign fresh   = (l_chg_i && !r_chg_i) ? OWN_RIGHT : OWN_LEFT;
  assign owner_o = coll_q ? owner_q : fresh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coll_q  <= 1'b0;
      owner_q <= OWN_LEFT;
    end else begin
      coll_q  <= master_i & match_i;
      owner_q <= owner_o;
    end
  end
endmodule

// File: rtl/dp_wr_gate.sv
module dp_wr_gate (
  input  logic en_i,
  input  logic we_i,
  input  logic inhibit_i,
  output logic we_o
);
  assign we_o = we_i & en_i & ~inhibit_i;
endmodule

// File: rtl/dp_busy_arb.sv
module dp_busy_arb
  import dp_arb_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  logic          l_en_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic          l_we_i,
  input  logic          l_inh_ni,
  input  logic          r_en_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic          r_we_i,
  input  logic          r_inh_ni,
  output logic          l_busy_o,
  output logic          r_busy_o,
  output logic          l_we_o,
  output logic          r_we_o
);
  logic              match;
  owner_e            owner;
  logic [NPORT-1:0]  en, we, inh_n, chg, lose, inhibit, we_g;
  logic [AW-1:0]     addr [NPORT];

  assign en[PL]    = l_en_i;
  assign en[PR]    = r_en_i;
  assign we[PL]    = l_we_i;
  assign we[PR]    = r_we_i;
  assign inh_n[PL] = l_inh_ni;
  assign inh_n[PR] = r_inh_ni;
  assign addr[PL]  = l_addr_i;
  assign addr[PR]  = r_addr_i;

  dp_addr_match #(.AW(AW)) u_match (
    .a_en_i  (l_en_i),
    .a_addr_i(l_addr_i),
    .b_en_i  (r_en_i),
    .b_addr_i(r_addr_i),
    .match_o (match)
  );

  dp_owner_ctl u_owner (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .master_i(master_i),
    .match_i (match),
    .l_chg_i (chg[PL]),
    .r_chg_i (chg[PR]),
    .owner_o (owner)
  );

  assign lose[PL] = master_i & match & (owner == OWN_RIGHT);
  assign lose[PR] = master_i & match & (owner == OWN_LEFT);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dp_port_track #(.AW(AW)) u_track (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en[p]),
      .addr_i(addr[p]),
      .chg_o (chg[p])
    );

    assign inhibit[p] = master_i ? lose[p] : ~inh_n[p];

    dp_wr_gate u_gate (
      .en_i     (en[p]),
      .we_i     (we[p]),
      .inhibit_i(inhibit[p]),
      .we_o     (we_g[p])
    );
  end

  assign l_busy_o = ~lose[PL];
  assign r_busy_o = ~lose[PR];
  assign l_we_o   = we_g[PL];
  assign r_we_o   = we_g[PR];
endmodule

// File: rtl/dp_busy_arb_chk.sv
module dp_busy_arb_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          master_i,
  input logic          l_en_i,
  input logic [AW-1:0] l_addr_i,
  input logic          l_we_i,
  input logic          l_inh_ni,
  input logic          r_en_i,
  input logic [AW-1:0] r_addr_i,
  input logic          r_we_i,
  input logic          r_inh_ni,
  input logic          l_busy_o,
  input logic          r_busy_o,
  input logic          l_we_o,
  input logic          r_we_o
);
  logic same;
  assign same = l_en_i && r_en_i && (l_addr_i == r_addr_i);

  assert_never_both_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!l_busy_o && !r_busy_o));

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !same |-> (l_busy_o && r_busy_o));

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_en_i || !r_en_i) |-> (l_busy_o && r_busy_o));

  assert_block_l_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_busy_o |-> !l_we_o);

  assert_block_r_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_busy_o |-> !r_we_o);

  assert_no_spurious_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(l_we_o && !(l_we_i && l_en_i)) && !(r_we_o && !(r_we_i && r_en_i))));

  assert_slave_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_o && r_busy_o
                   && (l_inh_ni || !l_we_o) && (r_inh_ni || !r_we_o)));

  assert_hold_l_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && same && !l_busy_o) |=> (!(master_i && same) || !l_busy_o));

  assert_hold_r_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && same && !r_busy_o) |=> (!(master_i && same) || !r_busy_o));

  assert_master_pick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && same) |-> (l_busy_o != r_busy_o));
endmodule

bind dp_busy_arb dp_busy_arb_chk #(.AW(AW)) u_chk (.*);

// File: tb/dp_busy_arb_tb.sv
module dp_busy_arb_tb;
  localparam int unsigned AW = 16;
  localparam real HALF = 2.0;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          master_i = 1'b1;
  logic          l_en_i = 1'b0, r_en_i = 1'b0;
  logic [AW-1:0] l_addr_i = '0, r_addr_i = '0;
  logic          l_we_i = 1'b0, r_we_i = 1'b0;
  logic          l_inh_ni = 1'b1, r_inh_ni = 1'b1;
  logic          l_busy_o, r_busy_o, l_we_o, r_we_o;

  int checks = 0;
  int errors = 0;

  // reference state
  logic          m_pl_en = 1'b0, m_pr_en = 1'b0;
  logic [AW-1:0] m_pl_a = '0, m_pr_a = '0;
  logic          m_coll = 1'b0, m_own_r = 1'b0;

  always #(HALF) clk_i = ~clk_i;

  dp_busy_arb #(.AW(AW)) u_dut (.*);

  function automatic logic [3:0] expect_now();
    logic mt, lc, rc, own_r, lb, rb, bl, br;
    mt    = l_en_i & r_en_i & (l_addr_i == r_addr_i);
    lc    = (l_en_i != m_pl_en) | (l_addr_i != m_pl_a);
    rc    = (r_en_i != m_pr_en) | (r_addr_i != m_pr_a);
    own_r = m_coll ? m_own_r : (lc & ~rc);
    lb    = ~(master_i & mt & own_r);
    rb    = ~(master_i & mt & ~own_r);
    bl    = master_i ? ~lb : ~l_inh_ni;
    br    = master_i ? ~rb : ~r_inh_ni;
    return {lb, rb, l_we_i & l_en_i & ~bl, r_we_i & r_en_i & ~br};
  endfunction

  task automatic model_commit();
    logic mt, lc, rc;
    mt = l_en_i & r_en_i & (l_addr_i == r_addr_i);
    lc = (l_en_i != m_pl_en) | (l_addr_i != m_pl_a);
    rc = (r_en_i != m_pr_en) | (r_addr_i != m_pr_a);
    m_own_r = m_coll ? m_own_r : (lc & ~rc);
    m_coll  = master_i & mt;
    m_pl_en = l_en_i; m_pl_a = l_addr_i;
    m_pr_en = r_en_i; m_pr_a = r_addr_i;
  endtask

  task automatic compare(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {l_busy_o, r_busy_o, l_we_o, r_we_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {lbusy,rbusy,lwe,rwe} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // apply one cycle of inputs; dir=1 compares against explicit value
  task automatic step(input logic ms, input logic le, input logic [AW-1:0] la,
                      input logic lw, input logic re, input logic [AW-1:0] ra,
                      input logic rw, input logic li, input logic ri,
                      input logic dir, input logic [3:0] exp, input string tag);
    @(negedge clk_i);
    master_i = ms; l_en_i = le; l_addr_i = la; l_we_i = lw;
    r_en_i = re; r_addr_i = ra; r_we_i = rw; l_inh_ni = li; r_inh_ni = ri;
    #1;
    compare(dir ? exp : expect_now(), tag);
    @(posedge clk_i);
    model_commit();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    #1;
    compare(4'b1100, "R1 reset state");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);

    // R8: both start matching together, left wins; R5 right write blocked at once
    step(1, 1, 16'h0005, 1, 1, 16'h0005, 1, 1, 1, 1, 4'b1010, "R8 tie left wins");
    // R9: unchanged collision keeps owner
    step(1, 1, 16'h0005, 1, 1, 16'h0005, 1, 1, 1, 1, 4'b1010, "R9 hold");
    // R7: right drops enable, busy clears that cycle
    step(1, 1, 16'h0005, 0, 0, 16'h0005, 1, 1, 1, 1, 4'b1100, "R7 enable drop");
    // R2: right settled at 7, then left arrives late and loses
    step(1, 0, 16'h0000, 0, 1, 16'h0007, 0, 1, 1, 1, 4'b1100, "R1 no match");
    step(1, 1, 16'h0007, 1, 1, 16'h0007, 0, 1, 1, 1, 4'b0100, "R2 late left loses");
    // R4: swapping read/write does not move busy
    step(1, 1, 16'h0007, 0, 1, 16'h0007, 1, 1, 1, 1, 4'b0101, "R4 we ignored");
    // R9: both move together to 9, owner still right
    step(1, 1, 16'h0009, 1, 1, 16'h0009, 0, 1, 1, 1, 4'b0100, "R9 joint move");
    // R7 + R10: mismatch clears busy, blocked write not replayed
    step(1, 1, 16'h0009, 0, 1, 16'h000a, 0, 1, 1, 1, 4'b1100, "R10 dropped write");
    step(1, 1, 16'h0009, 1, 1, 16'h000a, 0, 1, 1, 1, 4'b1110, "R10 fresh write");
    // R6: slave mode, no arbitration, inhibit inputs gate writes
    step(0, 1, 16'h0003, 1, 1, 16'h0003, 1, 0, 1, 1, 4'b1101, "R6 slave inhibit");
    step(0, 1, 16'h0003, 1, 1, 16'h0003, 1, 1, 0, 1, 4'b1110, "R6 slave inhibit r");
    // back to master with both stable and matching: fresh decision, tie left
    step(1, 1, 16'h0003, 1, 1, 16'h0003, 1, 1, 1, 1, 4'b1010, "R8 neither changed");

    // constrained random: small address space to force collisions; R3 R5 R7
    for (int i = 0; i < 3000; i++) begin
      step(($urandom_range(0, 9) != 0),
           ($urandom_range(0, 3) != 0), 16'($urandom_range(0, 3)), 1'($urandom),
           ($urandom_range(0, 3) != 0), 16'($urandom_range(0, 3)), 1'($urandom),
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0),
           0, 4'b0, "R1 R2 R3 R5 R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule